// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Transmitter

This block is an asynchronous serial transmitter for a shared line with many receivers. Each frame carries one extra bit that tells receivers whether the frame holds a station address or an ordinary data byte. Receivers can then skip data that is meant for other stations. Software, or a DMA engine that the transmit-empty interrupt triggers, writes bytes into a holding register. On a bit tick the sequencer moves a pending byte into the shift register and sends the frame least-significant bit first.

The registers are reached through a small write/read port with three addresses. Address 0 is the holding register. Address 1 is control: bit 0 is transmit enable, bit 1 is interrupt enable, bit 2 selects the ID frame type and bit 3 forces the line low. Address 2 is status: bit 0 is the empty flag and bit 1 is the end flag. When enable rises, the line stays at 1 for one whole frame time before any frame may start. A break is made by setting the force-low bit and then clearing enable. The line stays low until the force-low bit is released.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset the empty flag (status bit 0) and the end flag (status bit 1) read 1, control reads 0, tx_out is 1 and empty_irq is 0.
- R2: A frame is a 0 start bit, then DATA_W data bits with the least significant bit first, then the type bit, then a 1 stop bit. Each bit lasts from one bit_tick to the next.
- R3: The type bit equals control bit 2 at the moment the byte enters the shifter. Changing bit 2 while a frame is on the line only affects later frames.
- R4: After transmit enable (control bit 0) goes from 0 to 1, the line holds 1 for DATA_W+3 ticks before the first start bit can appear.
- R5: When the sequencer is ready or finishing a stop bit and the empty flag is 0, the next tick loads the holding register into the shifter. The same edge sets the empty flag to 1 and clears the end flag.
- R6: Writing status with bit 0 at 0 clears the empty flag. Writing status with bit 0 at 1 leaves it unchanged. Writing the holding register does not change the empty flag.
- R7: A DMA write (dma_wr) loads the holding register and clears the empty flag in the same cycle.
- R8: empty_irq is 1 exactly when interrupt enable, transmit enable and the empty flag are all 1.
- R9: The end flag becomes 1 at the end of a stop bit when nothing is pending. When a byte is pending at that point, the next start bit follows with no idle bit between.
- R10: While control bit 3 is 1, tx_out is 0 whatever the enable and the sequencer state. When bit 3 is 0 and enable is 0, tx_out is 1.
- R11: Clearing enable in the middle of a frame returns tx_out to 1 one cycle after the control write takes effect. The flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 data, 1 control, 2 status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| dma_wr | input | 1 | DMA write strobe to the holding register |
| dma_wdata | input | DATA_W | DMA write data |
| tx_out | output | 1 | Serial line output |
| empty_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench builds the block with DATA_W = 8, which gives 11-bit frames. It applies a tick every third clock, so a whole frame, the enable marking and back-to-back frames fit in a few hundred cycles. This short frame lets the bench exercise several cases on the real field layout: a type-bit change during a frame, a DMA reload during a stop bit, an abort during a frame, and a break held across a disable.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_MARK  = 2'd1,
    ST_READY = 2'd2,
    ST_SHIFT = 2'd3
  } tx_state_e;

  localparam logic [1:0] A_DATA   = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;

  localparam int C_EN  = 0;
  localparam int C_IRQ = 1;
  localparam int C_ID  = 2;
  localparam int C_BRK = 3;

  localparam int S_EMPTY = 0;
  localparam int S_END   = 1;

  function automatic int frame_bits(input int dw);
    return dw + 3;
  endfunction

endpackage

// File: rtl/mpu_regs.sv
module mpu_regs
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              load_evt,
  input  logic              end_evt,
  output logic [DATA_W-1:0] hold_q,
  output logic              en_q,
  output logic              irq_en_q,
  output logic              id_sel_q,
  output logic              brk_q,
  output logic              empty_q,
  output logic              tend_q,
  output logic [DATA_W-1:0] reg_rdata
);

  logic wr_data, wr_ctrl, wr_stat, sw_clear;

  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat  = reg_wr && (reg_addr == A_STATUS);
  assign sw_clear = wr_stat && !reg_wdata[S_EMPTY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (dma_wr) begin
      hold_q <= dma_wdata;
    end else if (wr_data) begin
      hold_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      id_sel_q <= 1'b0;
      brk_q    <= 1'b0;
    end else if (wr_ctrl) begin
      en_q     <= reg_wdata[C_EN];
      irq_en_q <= reg_wdata[C_IRQ];
      id_sel_q <= reg_wdata[C_ID];
      brk_q    <= reg_wdata[C_BRK];
    end
  end

  // Load refills the flag first; a write in the same cycle then makes new data pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
    end else if (dma_wr || sw_clear) begin
      empty_q <= 1'b0;
    end else if (load_evt) begin
      empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
    end else if (load_evt) begin
      tend_q <= 1'b0;
    end else if (end_evt) begin
      tend_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_DATA: reg_rdata = hold_q;
      A_CTRL: begin
        reg_rdata[C_EN]  = en_q;
        reg_rdata[C_IRQ] = irq_en_q;
        reg_rdata[C_ID]  = id_sel_q;
        reg_rdata[C_BRK] = brk_q;
      end
      A_STATUS: begin
        reg_rdata[S_EMPTY] = empty_q;
        reg_rdata[S_END]   = tend_q;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mpu_seq.sv
module mpu_seq
  import mpu_pkg::*;
#(
  parameter int FRAME_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic en,
  input  logic pending,
  output logic load_evt,
  output logic shift_evt,
  output logic end_evt,
  output logic shifting
);

  localparam int                CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FRAME_BITS - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_bit, mark_done;

  assign last_bit = (cnt_q == LAST);
  assign shifting = (state_q == ST_SHIFT);

  always_comb begin
    load_evt  = 1'b0;
    shift_evt = 1'b0;
    end_evt   = 1'b0;
    mark_done = 1'b0;
    if (en && bit_tick) begin
      unique case (state_q)
        ST_MARK:  mark_done = last_bit;
        ST_READY: load_evt  = pending;
        ST_SHIFT: begin
          if (last_bit) begin
            load_evt = pending;
            end_evt  = !pending;
          end else begin
            shift_evt = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else if (!en) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_q <= ST_MARK;
          cnt_q   <= '0;
        end
        ST_MARK: begin
          if (mark_done) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
          end else if (bit_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_READY: begin
          if (load_evt) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (bit_tick) begin
            if (last_bit) begin
              cnt_q <= '0;
              if (end_evt) state_q <= ST_READY;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/mpu_shifter.sv
module mpu_shifter #(
  parameter int DATA_W     = 8,
  parameter int FRAME_BITS = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              shift_evt,
  input  logic [DATA_W-1:0] data,
  input  logic              type_bit,
  output logic              ser_bit
);

  logic [FRAME_BITS-1:0] frame_q;

  function automatic logic [FRAME_BITS-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                        input logic t);
    return {1'b1, t, d, 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
    end else if (load_evt) begin
      frame_q <= pack_frame(data, type_bit);
    end else if (shift_evt) begin
      frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
    end
  end

  assign ser_bit = frame_q[0];

endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              tx_out,
  output logic              empty_irq
);

  localparam int FRAME_BITS = frame_bits(DATA_W);

  logic [DATA_W-1:0] hold_q;
  logic en_q, irq_en_q, id_sel_q, brk_q, empty_q, tend_q;
  logic load_evt, shift_evt, end_evt, shifting, ser_bit;

  mpu_regs #(.DATA_W(DATA_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dma_wr    (dma_wr),
    .dma_wdata (dma_wdata),
    .load_evt  (load_evt),
    .end_evt   (end_evt),
    .hold_q    (hold_q),
    .en_q      (en_q),
    .irq_en_q  (irq_en_q),
    .id_sel_q  (id_sel_q),
    .brk_q     (brk_q),
    .empty_q   (empty_q),
    .tend_q    (tend_q),
    .reg_rdata (reg_rdata)
  );

  mpu_seq #(.FRAME_BITS(FRAME_BITS)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .en        (en_q),
    .pending   (!empty_q),
    .load_evt  (load_evt),
    .shift_evt (shift_evt),
    .end_evt   (end_evt),
    .shifting  (shifting)
  );

  mpu_shifter #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS)) i_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .shift_evt (shift_evt),
    .data      (hold_q),
    .type_bit  (id_sel_q),
    .ser_bit   (ser_bit)
  );

  always_comb begin
    if (brk_q)         tx_out = 1'b0;
    else if (shifting) tx_out = ser_bit;
    else               tx_out = 1'b1;
  end

  assign empty_irq = irq_en_q && en_q && empty_q;

endmodule

// File: rtl/mpu_tx_chk.sv
module mpu_tx_chk
  import mpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dma_wr,
  input logic              tx_out,
  input logic              empty_irq,
  input logic              load_evt,
  input logic              shift_evt,
  input logic              end_evt,
  input logic              en_q,
  input logic              brk_q,
  input logic              empty_q,
  input logic              tend_q
);

  logic stat_clear;
  assign stat_clear = reg_wr && (reg_addr == A_STATUS) && !reg_wdata[S_EMPTY];

  p_load_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !dma_wr && !stat_clear) |=> (empty_q && !tend_q));

  p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_evt, shift_evt, end_evt}));

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!tx_out || brk_q));

  p_mark_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |=> (tx_out || brk_q));

  p_dma_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr |=> !empty_q);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    empty_irq |-> (empty_q && en_q));

  p_end_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> tend_q);

  p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> !tx_out);

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |=> (tx_out || brk_q));

endmodule

bind mp_uart_tx mpu_tx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dma_wr    (dma_wr),
  .tx_out    (tx_out),
  .empty_irq (empty_irq),
  .load_evt  (load_evt),
  .shift_evt (shift_evt),
  .end_evt   (end_evt),
  .en_q      (en_q),
  .brk_q     (brk_q),
  .empty_q   (empty_q),
  .tend_q    (tend_q)
);

// File: tb/test_mp_uart_tx.sv
module test_mp_uart_tx;

  localparam int DW     = 8;
  localparam int FB     = DW + 3;
  localparam int CLK_NS = 10;
  localparam int TDIV   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_tick = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd2;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          dma_wr = 1'b0;
  logic [DW-1:0] dma_wdata = '0;
  logic          tx_out, empty_irq;

  int checks = 0;
  int errors = 0;
  int tdiv   = 0;

  mp_uart_tx #(.DATA_W(DW)) i_mp_uart_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .tx_out(tx_out), .empty_irq(empty_irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv     <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    bit_tick <= rst_n && (tdiv == TDIV - 1);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number, marking count, queue of line bits.
  int   m_phase = 0;          // 0 off, 1 marking, 2 waiting, 3 sending
  int   m_mark  = 0;
  bit   m_bits[$];
  bit   m_empty = 1, m_tend = 1, m_en = 0, m_irq = 0, m_id = 0, m_brk = 0;
  logic [DW-1:0] m_hold = '0;

  function automatic void m_start();
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i < DW; i++) m_bits.push_back(m_hold[i]);
    m_bits.push_back(m_id);
    m_bits.push_back(1'b1);
    m_empty = 1;
    m_tend  = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_mark = 0; m_bits.delete();
      m_empty = 1; m_tend = 1; m_en = 0; m_irq = 0; m_id = 0; m_brk = 0; m_hold = '0;
    end else begin
      if (!m_en) begin
        m_phase = 0;
      end else if (m_phase == 0) begin
        m_phase = 1; m_mark = 0;
      end else if (bit_tick) begin
        if (m_phase == 1) begin
          m_mark++;
          if (m_mark == FB) m_phase = 2;
        end else if (m_phase == 2) begin
          if (!m_empty) begin m_start(); m_phase = 3; end
        end else begin
          void'(m_bits.pop_front());
          if (m_bits.size() == 0) begin
            if (!m_empty) m_start();
            else begin m_phase = 2; m_tend = 1; end
          end
        end
      end
      if (reg_wr && reg_addr == 2'd0 && !dma_wr) m_hold = reg_wdata;
      if (reg_wr && reg_addr == 2'd1) begin
        m_en = reg_wdata[0]; m_irq = reg_wdata[1]; m_id = reg_wdata[2]; m_brk = reg_wdata[3];
      end
      if (reg_wr && reg_addr == 2'd2 && !reg_wdata[0]) m_empty = 0;
      if (dma_wr) begin m_hold = dma_wdata; m_empty = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_tx;
      exp_tx = m_brk ? 1'b0 : ((m_phase == 3) ? m_bits[0] : 1'b1);
      check(tx_out == exp_tx, "R2 line vs model", tx_out, exp_tx);
      check(empty_irq == (m_irq && m_en && m_empty), "R8 irq vs model",
            empty_irq, m_irq && m_en && m_empty);
      if (!reg_wr && reg_addr == 2'd2)
        check(reg_rdata[1:0] == {m_tend, m_empty}, "R5 flags vs model",
              reg_rdata[1:0], {m_tend, m_empty});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic dma(input logic [DW-1:0] d);
    @(posedge clk); #1;
    dma_wr = 1'b1; dma_wdata = d;
    @(posedge clk); #1;
    dma_wr = 1'b0;
  endtask

  task automatic wait_flag(input int bitpos, input bit val);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (reg_rdata[bitpos] == val) return;
    end
  endtask

  task automatic capture(output logic [FB-1:0] f, output int idle);
    idle = 0;
    forever begin
      @(negedge clk);
      if (bit_tick) begin
        if (tx_out == 1'b0) break;
        idle++;
      end
    end
    f[0] = 1'b0;
    for (int i = 1; i < FB; i++) begin
      do @(negedge clk); while (!bit_tick);
      f[i] = tx_out;
    end
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [FB-1:0] f, f2;
    int idle, idle2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata[1:0] == 2'b11, "R1 status after reset", reg_rdata[1:0], 2'b11);
    check(tx_out == 1'b1 && empty_irq == 1'b0, "R1 line and irq", {tx_out, empty_irq}, 2'b10);
    reg_addr = 2'd1; #1;
    check(reg_rdata == '0, "R1 control after reset", reg_rdata, 0);
    reg_addr = 2'd2;

    wr(2'd0, 8'hA5);
    @(negedge clk);
    check(reg_rdata[0] == 1'b1, "R6 data write keeps empty", reg_rdata[0], 1);
    wr(2'd1, 8'b0111);
    @(negedge clk);
    check(empty_irq == 1'b1, "R8 irq with empty set", empty_irq, 1);
    fork
      capture(f, idle);
      begin
        wr(2'd2, 8'h00);
        @(negedge clk);
        check(empty_irq == 1'b0, "R8 irq drops when pending", empty_irq, 0);
        wait_flag(0, 1'b1);
        check(reg_rdata[1] == 1'b0, "R5 end flag cleared at load", reg_rdata[1], 0);
        wr(2'd1, 8'b0011);
      end
    join
    check(f == {1'b1, 1'b1, 8'hA5, 1'b0}, "R2 R3 ID frame bits", f, {1'b1, 1'b1, 8'hA5, 1'b0});
    check(idle >= FB, "R4 marking before first frame", idle, FB);
    wait_flag(1, 1'b1);
    check(reg_rdata[1] == 1'b1, "R9 end flag after stop", reg_rdata[1], 1);

    dma(8'h3C);
    @(negedge clk);
    check(reg_rdata[0] == 1'b0, "R7 dma clears empty", reg_rdata[0], 0);
    capture(f, idle);
    check(f == {1'b1, 1'b0, 8'h3C, 1'b0}, "R3 next frame uses new type", f, {1'b1, 1'b0, 8'h3C, 1'b0});
    wait_flag(1, 1'b1);

    fork
      begin capture(f, idle); capture(f2, idle2); end
      begin
        dma(8'h11);
        wait_flag(0, 1'b1);
        dma(8'h22);
      end
    join
    check(f == {1'b1, 1'b0, 8'h11, 1'b0}, "R2 first of pair", f, {1'b1, 1'b0, 8'h11, 1'b0});
    check(f2 == {1'b1, 1'b0, 8'h22, 1'b0}, "R2 second of pair", f2, {1'b1, 1'b0, 8'h22, 1'b0});
    check(idle2 == 0, "R9 back-to-back without idle", idle2, 0);
    wait_flag(1, 1'b1);

    wr(2'd1, 8'b0000);
    dma(8'h5A);
    wr(2'd2, 8'hFF);
    repeat (30) @(negedge clk);
    check(reg_rdata[0] == 1'b0, "R6 writing 1 keeps empty clear", reg_rdata[0], 0);
    check(tx_out == 1'b1, "R10 disabled line rests high", tx_out, 1);

    wr(2'd1, 8'b1000);
    @(negedge clk);
    check(tx_out == 1'b0, "R10 break forces low", tx_out, 0);
    repeat (20) @(negedge clk);
    check(tx_out == 1'b0, "R10 break holds", tx_out, 0);
    wr(2'd1, 8'b0000);
    @(negedge clk);
    check(tx_out == 1'b1, "R10 release returns high", tx_out, 1);

    wr(2'd1, 8'b0001);
    wait_flag(0, 1'b1);
    repeat (4 * TDIV) @(negedge clk);
    wr(2'd1, 8'b0000);
    @(posedge clk);
    @(negedge clk);
    check(tx_out == 1'b1, "R11 abort returns line high", tx_out, 1);
    check(reg_rdata[1:0] == 2'b01, "R11 flags kept after abort", reg_rdata[1:0], 2'b01);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule